// File: doc/BRIEF.md
# Calibrated Temperature Conversion Unit

This unit turns a raw 12-bit code from a temperature-sensing converter into a signed temperature in millidegrees Celsius. It applies the calibration values of the device: a gain error, a base calibration temperature, a slope trim with a sign qualifier, and one offset per sensor. A single start strobe launches a conversion. The unit works through a fixed sequence: a constant numerator, two truncating divisions by calibration-dependent denominators, a multiply by the offset-corrected code, and an arithmetic scale-back. It then raises a one-cycle done strobe, and the result stays on the output until the next conversion finishes.

Next to the per-conversion result, the unit keeps a running maximum over a group of sensors. A conversion that comes out implausibly hot is counted as zero before it joins the maximum. This keeps a bad first sample from looking like a real overheat. A clear input starts a new group. Both divisions share one iterative restoring divider that resolves one quotient bit per cycle, so the datapath has no wide combinational divider.

Top module: `tempconv_unit`

## Requirements
- R1: Only bits [11:0] of `raw_i` take part in a conversion. Bits [15:12] have no effect on `temp_o` or `max_o`.
- R2: Let q = trunc(trunc(1627604160 / (165 + S)) / (10000 + G)), where S is the effective slope trim and G is the gain error. The result is `temp_o` = 500·C − ((q · (code − offset − 3350)) >>> 3), where C is the calibration temperature. All values are signed 32-bit and the multiply keeps its low 32 bits.
- R3: A start accepted at clock edge E produces `done_o` high for exactly one cycle, after edge E+67. `temp_o` changes only at that edge and holds its value otherwise.
- R4: While `cal_valid_i` is 0, the conversion uses gain error 512, offset 260 for every sensor, calibration temperature 40 and slope trim 0. All other calibration inputs are ignored.
- R5: While `cal_valid_i` is 1, the offset is field k of `offsets_i` (bits [9k+8:9k]) for sensor index k below 5. An index of 5 or more uses offset 260.
- R6: The slope trim is the 6-bit magnitude `slope_mag_i`. It is negated only when `slope_sign_i` and `id_bit_i` are both 1.
- R7: A result above 200000 joins the group maximum as 0. `temp_o` still carries the unfiltered value.
- R8: At each done edge, `max_o` becomes the larger of its current value and the filtered result.
- R9: `clr_i` high at an edge sets `max_o` to -2147483648 (0x80000000). When it coincides with a done edge, the clear wins and that result is not folded in.
- R10: A start that arrives while a conversion is in flight is ignored. This includes the done edge itself. A start on the edge right after done is accepted.
- R11: Synchronous reset clears `done_o` and `temp_o` to 0, sets `max_o` to -2147483648 and returns the unit to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a conversion when idle |
| raw_i | input | 16 | Raw converter word; only the low 12 bits count |
| sens_i | input | 3 | Sensor index selecting the offset |
| cal_valid_i | input | 1 | 1: use calibration inputs, 0: use defaults |
| gain_err_i | input | 10 | Gain error calibration value |
| cal_temp_i | input | 6 | Base calibration temperature in degrees |
| slope_mag_i | input | 6 | Slope trim magnitude |
| slope_sign_i | input | 1 | Slope trim sign bit |
| id_bit_i | input | 1 | Qualifier that enables the slope sign |
| offsets_i | input | 45 | Five 9-bit per-sensor offsets, sensor k at bits [9k+8:9k] |
| clr_i | input | 1 | Resets the group maximum |
| temp_o | output | 32 | Signed converted temperature, millidegrees |
| done_o | output | 1 | One-cycle strobe when `temp_o` updates |
| max_o | output | 32 | Signed running group maximum, filtered |

## Verification
A wrong divider step count or a wrong sequencer transition moves `done_o` off its 67-cycle slot. The per-clock comparison catches that on the first conversion. A wrong bit in either quotient, or a mis-selected offset, denominator or sign, appears in `temp_o` on the same done edge. Because the filtered value also feeds `max_o` there, filter or compare faults become visible in the same cycle. Faults in clear priority and in busy-start rejection show at the done edge they disturb: a missing or extra strobe, or a maximum that differs from the model's.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_DW        = 32;
  localparam int TC_NUM_SEED  = 203450520 <<< 3;
  localparam int TC_D1_BASE   = 165;
  localparam int TC_D2_BASE   = 10000;
  localparam int TC_CODE_BIAS = 3350;
  localparam int TC_SCALE_SH  = 3;
  localparam int TC_CAL_MULT  = 500;
  localparam int TC_FILT_LIM  = 200000;
  localparam int TC_DEF_GE    = 512;
  localparam int TC_DEF_OFS   = 260;
  localparam int TC_DEF_CT    = 40;
  localparam logic signed [TC_DW-1:0] TC_INT_MIN = 32'sh8000_0000;

  typedef enum logic [2:0] {
    TC_IDLE = 3'd0,
    TC_DIV1 = 3'd1,
    TC_DIV2 = 3'd2,
    TC_MULT = 3'd3
  } tc_state_e;
endpackage

// File: rtl/tc_restore_div.sv
module tc_restore_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic         fin_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign fits    = ~trial[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        quo_q <= dvd_i;
        rem_q <= '0;
        dvs_q <= dvs_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        quo_q <= {quo_q[W-2:0], fits};
        rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W - 1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
  assign fin_o = fin_q;

  // R2
  div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> (rem_q < dvs_q));

  // R3
  div_fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> !fin_q);
endmodule

// File: rtl/tc_calib_sel.sv
module tc_calib_sel
  import tc_pkg::*;
#(
  parameter int NSENS = 5,
  parameter int OFS_W = 9,
  parameter int GE_W  = 10,
  parameter int CT_W  = 6,
  parameter int SL_W  = 6,
  parameter int SEL_W = 3
) (
  input  logic                    cal_valid_i,
  input  logic [GE_W-1:0]         gain_err_i,
  input  logic [CT_W-1:0]         cal_temp_i,
  input  logic [SL_W-1:0]         slope_mag_i,
  input  logic                    slope_sign_i,
  input  logic                    id_bit_i,
  input  logic [NSENS*OFS_W-1:0]  offsets_i,
  input  logic [SEL_W-1:0]        sens_i,
  output logic signed [TC_DW-1:0] d1_o,
  output logic signed [TC_DW-1:0] d2_o,
  output logic signed [TC_DW-1:0] ofs_o,
  output logic signed [TC_DW-1:0] cal500_o
);
  logic [OFS_W-1:0] ofs_arr [NSENS];

  for (genvar k = 0; k < NSENS; k++) begin : g_unpack
    assign ofs_arr[k] = offsets_i[k*OFS_W +: OFS_W];
  end

  int slope_eff, ofs_pick;

  always_comb begin
    ofs_pick = TC_DEF_OFS;
    for (int k = 0; k < NSENS; k++) begin
      if (sens_i == SEL_W'(k)) ofs_pick = int'(ofs_arr[k]);
    end
    slope_eff = int'(slope_mag_i);
    if (slope_sign_i && id_bit_i) slope_eff = -slope_eff;

    if (cal_valid_i) begin
      d1_o     = TC_D1_BASE + slope_eff;
      d2_o     = TC_D2_BASE + int'(gain_err_i);
      ofs_o    = ofs_pick;
      cal500_o = int'(cal_temp_i) * TC_CAL_MULT;
    end else begin
      d1_o     = TC_D1_BASE;
      d2_o     = TC_D2_BASE + TC_DEF_GE;
      ofs_o    = TC_DEF_OFS;
      cal500_o = TC_DEF_CT * TC_CAL_MULT;
    end
  end
endmodule

// File: rtl/tc_peak_track.sv
module tc_peak_track
  import tc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic                    clr_i,
  input  logic signed [TC_DW-1:0] val_i,
  output logic signed [TC_DW-1:0] max_o
);
  logic signed [TC_DW-1:0] filt;

  assign filt = (val_i > TC_FILT_LIM) ? '0 : val_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      max_o <= TC_INT_MIN;
    end else if (upd_i && (filt > max_o)) begin
      max_o <= filt;
    end
  end

  // R7
  peak_cap_chk: assert property (@(posedge clk) disable iff (rst)
    max_o <= TC_FILT_LIM);

  // R9
  peak_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (max_o == TC_INT_MIN));

  // R8
  peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (max_o >= $past(max_o)));
endmodule

// File: rtl/tempconv_unit.sv
module tempconv_unit
  import tc_pkg::*;
#(
  parameter int NSENS    = 5,
  parameter int RAW_IN_W = 16,
  parameter int RAW_W    = 12,
  parameter int OFS_W    = 9,
  parameter int GE_W     = 10,
  parameter int CT_W     = 6,
  parameter int SL_W     = 6,
  localparam int SEL_W   = (NSENS > 1) ? $clog2(NSENS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [RAW_IN_W-1:0]     raw_i,
  input  logic [SEL_W-1:0]        sens_i,
  input  logic                    cal_valid_i,
  input  logic [GE_W-1:0]         gain_err_i,
  input  logic [CT_W-1:0]         cal_temp_i,
  input  logic [SL_W-1:0]         slope_mag_i,
  input  logic                    slope_sign_i,
  input  logic                    id_bit_i,
  input  logic [NSENS*OFS_W-1:0]  offsets_i,
  input  logic                    clr_i,
  output logic signed [TC_DW-1:0] temp_o,
  output logic                    done_o,
  output logic signed [TC_DW-1:0] max_o
);
  localparam logic [RAW_IN_W-1:0] RAW_MASK = RAW_IN_W'((1 << RAW_W) - 1);

  tc_state_e st;

  logic signed [TC_DW-1:0] d1_c, d2_c, ofs_c, cal500_c;
  logic signed [TC_DW-1:0] d2_q, diff_q, cal500_q, prod_q, res_c;
  logic signed [TC_DW-1:0] raw_code;
  logic                    div_load, div_fin;
  logic [TC_DW-1:0]        div_dvd, div_dvs, div_quo;

  assign raw_code = int'(raw_i & RAW_MASK);

  tc_calib_sel #(
    .NSENS(NSENS), .OFS_W(OFS_W), .GE_W(GE_W),
    .CT_W(CT_W), .SL_W(SL_W), .SEL_W(SEL_W)
  ) u_cal (
    .cal_valid_i (cal_valid_i),
    .gain_err_i  (gain_err_i),
    .cal_temp_i  (cal_temp_i),
    .slope_mag_i (slope_mag_i),
    .slope_sign_i(slope_sign_i),
    .id_bit_i    (id_bit_i),
    .offsets_i   (offsets_i),
    .sens_i      (sens_i),
    .d1_o        (d1_c),
    .d2_o        (d2_c),
    .ofs_o       (ofs_c),
    .cal500_o    (cal500_c)
  );

  always_comb begin
    div_load = 1'b0;
    div_dvd  = TC_NUM_SEED;
    div_dvs  = d1_c;
    if (st == TC_IDLE && start_i) begin
      div_load = 1'b1;
    end else if (st == TC_DIV1 && div_fin) begin
      div_load = 1'b1;
      div_dvd  = div_quo;
      div_dvs  = d2_q;
    end
  end

  tc_restore_div #(.W(TC_DW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .load_i(div_load),
    .dvd_i (div_dvd),
    .dvs_i (div_dvs),
    .quo_o (div_quo),
    .fin_o (div_fin)
  );

  assign res_c = cal500_q - (prod_q >>> TC_SCALE_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TC_IDLE;
      d2_q     <= '0;
      diff_q   <= '0;
      cal500_q <= '0;
      prod_q   <= '0;
      temp_o   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        TC_IDLE: if (start_i) begin
          d2_q     <= d2_c;
          diff_q   <= raw_code - ofs_c - TC_CODE_BIAS;
          cal500_q <= cal500_c;
          st       <= TC_DIV1;
        end
        TC_DIV1: if (div_fin) st <= TC_DIV2;
        TC_DIV2: if (div_fin) begin
          prod_q <= $signed(div_quo) * diff_q;
          st     <= TC_MULT;
        end
        TC_MULT: begin
          temp_o <= res_c;
          done_o <= 1'b1;
          st     <= TC_IDLE;
        end
        default: st <= TC_IDLE;
      endcase
    end
  end

  tc_peak_track u_peak (
    .clk  (clk),
    .rst  (rst),
    .upd_i(st == TC_MULT),
    .clr_i(clr_i),
    .val_i(res_c),
    .max_o(max_o)
  );

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st != TC_IDLE && start_i) |=> (st != TC_IDLE || done_o));

  // R3
  temp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(temp_o));
endmodule

// File: tb/tempconv_unit_test.sv
module tempconv_unit_test;
  localparam int CLK_NS = 10;
  localparam int LAT    = 67;
  localparam int INT_MIN_V = 32'sh8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] raw_i = '0;
  logic [2:0]  sens_i = '0;
  logic        cal_valid_i = 1'b0;
  logic [9:0]  gain_err_i = '0;
  logic [5:0]  cal_temp_i = '0;
  logic [5:0]  slope_mag_i = '0;
  logic        slope_sign_i = 1'b0;
  logic        id_bit_i = 1'b0;
  logic [44:0] offsets_i = '0;
  logic        clr_i = 1'b0;
  logic signed [31:0] temp_o, max_o;
  logic        done_o;

  tempconv_unit uut (
    .clk(clk), .rst(rst), .start_i(start_i), .raw_i(raw_i), .sens_i(sens_i),
    .cal_valid_i(cal_valid_i), .gain_err_i(gain_err_i), .cal_temp_i(cal_temp_i),
    .slope_mag_i(slope_mag_i), .slope_sign_i(slope_sign_i), .id_bit_i(id_bit_i),
    .offsets_i(offsets_i), .clr_i(clr_i),
    .temp_o(temp_o), .done_o(done_o), .max_o(max_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    armed = 0;
  string scen = "R11";

  // behavioural reference model
  bit m_busy = 0;
  int m_left = 0, m_res = 0;
  int e_temp = 0, e_max = INT_MIN_V;
  bit e_done = 0;

  function automatic int ref_conv(input int raw, input int sens);
    int ge, ct, ofs, sl, t;
    if (cal_valid_i) begin
      ge  = int'(gain_err_i);
      ct  = int'(cal_temp_i);
      ofs = (sens < 5) ? int'(offsets_i[sens*9 +: 9]) : 260;
      sl  = int'(slope_mag_i);
      if (slope_sign_i && id_bit_i) sl = -sl;
    end else begin
      ge = 512; ct = 40; ofs = 260; sl = 0;
    end
    t = 203450520 <<< 3;
    t = t / (165 + sl);
    t = t / (10000 + ge);
    t = t * ((raw & 'hfff) - ofs - 3350);
    t = t >>> 3;
    return ct * 500 - t;
  endfunction

  always @(posedge clk) begin
    bit fire;
    int f;
    cyc++;
    if (rst) begin
      m_busy = 0; e_done = 0; e_temp = 0; e_max = INT_MIN_V;
    end else begin
      fire = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; fire = 1; end
      end else if (start_i) begin
        m_res  = ref_conv(int'(raw_i), int'(sens_i));
        m_busy = 1;
        m_left = LAT;
      end
      e_done = fire;
      if (fire) e_temp = m_res;
      if (clr_i) e_max = INT_MIN_V;
      else if (fire) begin
        f = (m_res > 200000) ? 0 : m_res;
        if (f > e_max) e_max = f;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      n_vec++;
      if (done_o !== e_done) begin
        n_bad++;
        $display("FAIL R3 [%s] done_o=%0b expected %0b at cycle %0d", scen, done_o, e_done, cyc);
      end
      if (temp_o !== e_temp) begin
        n_bad++;
        $display("FAIL R2 [%s] temp_o=%0d expected %0d at cycle %0d", scen, temp_o, e_temp, cyc);
      end
      if (max_o !== e_max) begin
        n_bad++;
        $display("FAIL R8 [%s] max_o=%0d expected %0d at cycle %0d", scen, max_o, e_max, cyc);
      end
    end
  end

  task automatic edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic go(input logic [15:0] raw, input logic [2:0] s);
    @(negedge clk);
    raw_i = raw; sens_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic conv(input logic [15:0] raw, input logic [2:0] s);
    go(raw, s);
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    cyc = 0;
    while (cyc < 200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    armed = 1;
    // R11: reset state
    scen = "R11";
    edges(2);
    n_vec++;
    if (done_o !== 1'b0 || temp_o !== 0 || max_o !== INT_MIN_V) begin
      n_bad++;
      $display("FAIL R11 reset state done=%0b temp=%0d max=%0d expected 0/0/%0d",
               done_o, temp_o, max_o, INT_MIN_V);
    end

    // R4: defaults, calibration inputs carry junk
    scen = "R4";
    cal_valid_i = 1'b0; gain_err_i = 10'd77; cal_temp_i = 6'd9;
    slope_mag_i = 6'd30; slope_sign_i = 1'b1; id_bit_i = 1'b1;
    offsets_i = {9'd11, 9'd22, 9'd33, 9'd44, 9'd55};
    conv(16'd3610, 3'd2);
    conv(16'd4095, 3'd4);
    conv(16'd3000, 3'd7);
    // R7: bogus hot reading, filtered out of the maximum
    scen = "R7";
    conv(16'd0, 3'd0);
    conv(16'd12, 3'd1);

    // R5: calibrated offsets per sensor, plus out-of-range indices
    scen = "R5";
    clr_i = 1'b1; edges(1); clr_i = 1'b0;
    cal_valid_i = 1'b1; gain_err_i = 10'd300; cal_temp_i = 6'd45;
    slope_mag_i = 6'd0; slope_sign_i = 1'b0; id_bit_i = 1'b0;
    offsets_i = {9'd511, 9'd300, 9'd200, 9'd100, 9'd5};
    for (int k = 0; k < 8; k++) conv(16'd3700 - 16'(k*40), 3'(k));

    // R2: extreme gain values
    scen = "R2";
    gain_err_i = 10'd0;    conv(16'd3800, 3'd1);
    gain_err_i = 10'd1023; conv(16'd2500, 3'd3);

    // R6: slope sign qualification
    scen = "R6";
    slope_mag_i = 6'd63; slope_sign_i = 1'b1; id_bit_i = 1'b0; conv(16'd3500, 3'd0);
    slope_sign_i = 1'b1; id_bit_i = 1'b1; conv(16'd3500, 3'd0);
    slope_sign_i = 1'b0; id_bit_i = 1'b1; conv(16'd3500, 3'd0);
    slope_mag_i = 6'd17; slope_sign_i = 1'b1; id_bit_i = 1'b1; conv(16'd100, 3'd2);

    // R1: upper raw bits have no effect
    scen = "R1";
    conv(16'hF9A0, 3'd1);
    conv(16'h09A0, 3'd1);
    conv(16'h5FFF, 3'd4);

    // R10: starts while busy, including at the done edge, then one right after
    scen = "R10";
    go(16'd3300, 3'd2);
    edges(10);
    start_i = 1'b1; raw_i = 16'd100; edges(1); start_i = 1'b0;
    edges(LAT - 12);
    start_i = 1'b1; raw_i = 16'd200; edges(1);
    raw_i = 16'd3900; edges(1); start_i = 1'b0;
    while (m_busy) @(negedge clk);

    // R9: clear mid-group and clear coinciding with done
    scen = "R9";
    slope_mag_i = 6'd0;
    conv(16'd3100, 3'd0);
    go(16'd3200, 3'd1);
    edges(20);
    clr_i = 1'b1; edges(1); clr_i = 1'b0;
    edges(LAT - 22);
    clr_i = 1'b1; edges(1); clr_i = 1'b0;
    while (m_busy) @(negedge clk);
    conv(16'd4000, 3'd3);
    // R8: group of negatives then a warmer one
    scen = "R8";
    clr_i = 1'b1; edges(1); clr_i = 1'b0;
    conv(16'd4095, 3'd0);
    conv(16'd4050, 3'd1);
    conv(16'd3900, 3'd2);
    edges(3);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule